// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 96 level-sensitive interrupt sources and turns them into two request lines, one for normal interrupts (IRQ) and one for fast interrupts (FIQ). Each source can be disabled by a mask bit, forced active by software, and given a six-bit priority and a routing choice that sends it to either output. For each output, the controller selects the most urgent pending source, records its number in an active-vector register and raises the matching request line.

A selection stays frozen until software acknowledges it by writing a control register. Only after that write does the controller look for a new winner. All configuration and status is reached over a simple single-cycle 32-bit read/write bus with word addresses. Write data is sampled on the rising clock edge while `bus_sel` and `bus_wr` are high. Read data is combinational from the addressed register.

Sources are grouped into three banks of 32: source n is bit n%32 of bank n/32. Bank b occupies word addresses 16+8b to 23+8b, at these offsets:

- +0: mask, read-only.
- +1: mask set.
- +2: mask clear.
- +3: software set. A read returns the software-forced bits.
- +4: software clear.
- +5: pending IRQ, read-only.
- +6: pending FIQ, read-only.

Other addresses are:

- Address 0: control register.
- Address 1: IRQ active-vector register.
- Address 2: FIQ active-vector register.
- Addresses 64+n: the level register of source n.

Top module: `vec_intc`

## Requirements
- R1: After reset every mask bit reads 1, every level register reads 0, both request lines are low and both active-vector registers read 0.
- R2: Writing a 1 to a bit of a bank's mask-set register (offset +1) masks that source. Writing a 1 to a bit of its mask-clear register (offset +2) unmasks it. Zero bits leave masks unchanged, and the mask register (offset +0) reads 1 for a masked source.
- R3: Writing a 1 to a bit of the software-set register (offset +3) forces that source pending. Writing a 1 to the software-clear register (offset +4) removes the forced request. A read of offset +3 returns the forced bits.
- R4: A source is pending when its input is high or it is forced, and it is unmasked. It appears in the pending-FIQ register (offset +6) if bit 0 of its level register is 1, and otherwise in the pending-IRQ register (offset +5). A masked source appears in neither register and raises no request.
- R5: Among pending sources of one output, the lowest priority value (level register bits [7:2]) wins. On a tie, the lower source number wins.
- R6: With no selection held and a source pending, the request line rises on the next clock edge. The active-vector register reads bit 31 = 1 and bits [6:0] = winning source number, with all other bits 0.
- R7: While a selection is held, the request line and the active vector stay unchanged, even if a more urgent source becomes pending or the winner stops being pending.
- R8: Writing control (address 0) with bit 0 = 1 acknowledges IRQ, and with bit 1 = 1 acknowledges FIQ. Both may be set in one write. The acknowledged request is low in the cycle after the write edge, and arbitration runs again on the following edge.
- R9: A level register (address 64+n) stores bits [7:0] of the write data and reads them back with bits [31:8] = 0.
- R10: Source n is controlled by bit n%32 of the registers of bank n/32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | 96 | Level-sensitive interrupt inputs, bit n = source n |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_req | output | 1 | IRQ request, held until acknowledged |
| fiq_req | output | 1 | FIQ request, held until acknowledged |

## Verification
The hardest situation to reach is a more urgent source arriving while a less urgent selection is still held. Reaching it needs the first winner latched before the second source exists. The bench forces a low-urgency source through the software-set register and lets it be selected. It then forces a higher-urgency source and waits several cycles before checking that the vector is unchanged. Only then does it acknowledge, confirming that the request drops for one cycle and that the newcomer is chosen on the following edge.

// File: rtl/vintc_pkg.sv
// Shared constants and types of the vectored interrupt controller.
package vintc_pkg;
    localparam int NUM_SRC  = 96;
    localparam int BANK_W   = 32;
    localparam int PRIO_W   = 6;
    localparam int LVL_W    = 8;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;

    localparam int ADR_CTRL      = 0;
    localparam int ADR_ACT_IRQ   = 1;
    localparam int ADR_ACT_FIQ   = 2;
    localparam int ADR_BANK_BASE = 16;
    localparam int BANK_STRIDE   = 8;
    localparam int ADR_LVL_BASE  = 64;

    // Register offsets inside one bank window.
    typedef enum logic [2:0] {
        BK_MASK = 3'd0,
        BK_MSET = 3'd1,
        BK_MCLR = 3'd2,
        BK_SSET = 3'd3,
        BK_SCLR = 3'd4,
        BK_PIRQ = 3'd5,
        BK_PFIQ = 3'd6,
        BK_RSVD = 3'd7
    } bank_off_e;
endpackage

// File: rtl/vintc_bank.sv
// One bank of mask and software-force bits.
// Assumes the four write enables are mutually exclusive (distinct addresses).
module vintc_bank #(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mset_we,
    input  logic              mclr_we,
    input  logic              sset_we,
    input  logic              sclr_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] mask_q,
    output logic [BANK_W-1:0] soft_q
);
    // Mask bits: reset to all masked, write-1-to-set / write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mset_we) mask_q <= mask_q | wdata;
        else if (mclr_we) mask_q <= mask_q & ~wdata;
    end

    // Software-force bits: reset clear, write-1-to-set / write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       soft_q <= '0;
        else if (sset_we) soft_q <= soft_q | wdata;
        else if (sclr_we) soft_q <= soft_q & ~wdata;
    end

    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mset_we |=> ((mask_q & $past(wdata)) == $past(wdata)));
    p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_we |=> ((mask_q & $past(wdata)) == '0));
    p_soft_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclr_we |=> ((soft_q & $past(wdata)) == '0));
endmodule

// File: rtl/vintc_arb.sv
// Priority arbiter with hold-until-acknowledge for one request output.
// Lowest priority value wins, ties go to the lowest index.
// Assumes pend is already masked and routed to this output.
module vintc_arb #(
    parameter int NUM_SRC = 96,
    parameter int PRIO_W  = 6,
    localparam int VEC_W  = $clog2(NUM_SRC)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic                           ack,
    output logic                           active_q,
    output logic [VEC_W-1:0]               vec_q
);
    logic              found;
    logic [PRIO_W-1:0] best_p;
    logic [VEC_W-1:0]  best_i;

    // Linear search from the top index down so a tie keeps the lower index.
    always_comb begin
        found  = 1'b0;
        best_p = '0;
        best_i = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && (!found || prio[i] <= best_p)) begin
                found  = 1'b1;
                best_p = prio[i];
                best_i = VEC_W'(i);
            end
        end
    end

    // Latch a winner when idle; release only on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            vec_q    <= '0;
        end else if (ack) begin
            active_q <= 1'b0;
        end else if (!active_q && found) begin
            active_q <= 1'b1;
            vec_q    <= best_i;
        end
    end

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !ack) |=> (active_q && $stable(vec_q)));
    p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !active_q);
    p_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !ack && (|pend)) |=> active_q);
    p_vec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (int'(vec_q) < NUM_SRC));
endmodule

// File: rtl/vec_intc.sv
// Top of the vectored interrupt controller: bus decode, per-source level
// registers, bank instances and the two arbiters.
// Assumes a single-cycle bus: writes take effect on the clock edge while
// bus_sel && bus_wr, and reads are combinational.
module vec_intc
    import vintc_pkg::*;
#(
    parameter int N_SRC   = NUM_SRC,
    parameter int BW      = BANK_W,
    parameter int PW      = PRIO_W,
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W,
    localparam int NBANK  = (N_SRC + BW - 1) / BW,
    localparam int BIW    = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int VEC_W  = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_level,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             irq_req,
    output logic             fiq_req
);
    logic                       wr;
    int                         bk_off;
    int                         lvl_off;
    logic                       bank_hit;
    logic                       lvl_hit;
    logic [BIW-1:0]             bank_idx;
    bank_off_e                  bank_reg;
    logic [VEC_W-1:0]           lvl_idx;
    logic [N_SRC-1:0][LVL_W-1:0] level_q;
    logic [N_SRC-1:0][PW-1:0]   prio;
    logic [N_SRC-1:0]           route_fiq;
    logic [N_SRC-1:0]           mask_all;
    logic [N_SRC-1:0]           soft_all;
    logic [N_SRC-1:0]           pend_raw;
    logic [N_SRC-1:0]           pend_irq;
    logic [N_SRC-1:0]           pend_fiq;
    logic [BW-1:0]              mask_w  [NBANK];
    logic [BW-1:0]              soft_w  [NBANK];
    logic [BW-1:0]              pirq_w  [NBANK];
    logic [BW-1:0]              pfiq_w  [NBANK];
    logic                       irq_ack;
    logic                       fiq_ack;
    logic                       irq_act;
    logic                       fiq_act;
    logic [VEC_W-1:0]           irq_vec;
    logic [VEC_W-1:0]           fiq_vec;

    assign wr = bus_sel && bus_wr;

    // Address decode into bank window and level-register window.
    always_comb begin
        bk_off   = int'(bus_addr) - ADR_BANK_BASE;
        lvl_off  = int'(bus_addr) - ADR_LVL_BASE;
        bank_hit = (bk_off >= 0) && (bk_off < NBANK * BANK_STRIDE);
        lvl_hit  = (lvl_off >= 0) && (lvl_off < N_SRC);
        bank_idx = BIW'(bk_off / BANK_STRIDE);
        bank_reg = bank_off_e'(3'(bk_off));
        lvl_idx  = VEC_W'(lvl_off);
    end

    assign irq_ack = wr && (int'(bus_addr) == ADR_CTRL) && bus_wdata[0];
    assign fiq_ack = wr && (int'(bus_addr) == ADR_CTRL) && bus_wdata[1];

    // Per-source level registers: priority in [7:2], FIQ routing in [0].
    always_ff @(posedge clk) begin
        if (!rst_n)                level_q <= '0;
        else if (wr && lvl_hit)    level_q[lvl_idx] <= bus_wdata[LVL_W-1:0];
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_lvl
        assign prio[s]      = level_q[s][PW+1:2];
        assign route_fiq[s] = level_q[s][0];
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int LO = b * BW;
        localparam int WB = ((LO + BW) <= N_SRC) ? BW : (N_SRC - LO);
        logic sel_b;
        logic [BW-1:0] m_q;
        logic [BW-1:0] s_q;
        assign sel_b = wr && bank_hit && (bank_idx == BIW'(b));
        vintc_bank #(.BANK_W(BW)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .mset_we (sel_b && (bank_reg == BK_MSET)),
            .mclr_we (sel_b && (bank_reg == BK_MCLR)),
            .sset_we (sel_b && (bank_reg == BK_SSET)),
            .sclr_we (sel_b && (bank_reg == BK_SCLR)),
            .wdata   (bus_wdata[BW-1:0]),
            .mask_q  (m_q),
            .soft_q  (s_q)
        );
        assign mask_all[LO +: WB] = m_q[WB-1:0];
        assign soft_all[LO +: WB] = s_q[WB-1:0];
        assign mask_w[b] = m_q;
        assign soft_w[b] = s_q;
        assign pirq_w[b] = BW'(pend_irq[LO +: WB]);
        assign pfiq_w[b] = BW'(pend_fiq[LO +: WB]);
    end

    assign pend_raw = (src_level | soft_all) & ~mask_all;
    assign pend_irq = pend_raw & ~route_fiq;
    assign pend_fiq = pend_raw & route_fiq;

    vintc_arb #(.NUM_SRC(N_SRC), .PRIO_W(PW)) i_arb_irq (
        .clk(clk), .rst_n(rst_n), .pend(pend_irq), .prio(prio),
        .ack(irq_ack), .active_q(irq_act), .vec_q(irq_vec)
    );

    vintc_arb #(.NUM_SRC(N_SRC), .PRIO_W(PW)) i_arb_fiq (
        .clk(clk), .rst_n(rst_n), .pend(pend_fiq), .prio(prio),
        .ack(fiq_ack), .active_q(fiq_act), .vec_q(fiq_vec)
    );

    assign irq_req = irq_act;
    assign fiq_req = fiq_act;

    // Combinational read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == ADR_ACT_IRQ) begin
            bus_rdata = {irq_act, (DW-1-VEC_W)'(0), irq_vec};
        end else if (int'(bus_addr) == ADR_ACT_FIQ) begin
            bus_rdata = {fiq_act, (DW-1-VEC_W)'(0), fiq_vec};
        end else if (lvl_hit) begin
            bus_rdata = DW'(level_q[lvl_idx]);
        end else if (bank_hit) begin
            case (bank_reg)
                BK_MASK: bus_rdata = DW'(mask_w[bank_idx]);
                BK_SSET: bus_rdata = DW'(soft_w[bank_idx]);
                BK_PIRQ: bus_rdata = DW'(pirq_w[bank_idx]);
                BK_PFIQ: bus_rdata = DW'(pfiq_w[bank_idx]);
                default: bus_rdata = '0;
            endcase
        end
    end

    p_req_low_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack || fiq_ack) |=> ((!irq_req || !$past(irq_ack)) && (!fiq_req || !$past(fiq_ack))));
    p_masked_no_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_irq | pend_fiq) & mask_all) == '0);
endmodule

// File: tb/test_vec_intc.sv
// Directed bench for vec_intc: one task per scenario, each checking itself.
module test_vec_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src_level = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic        fiq_req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    localparam int A_CTRL = 0;
    localparam int A_AIRQ = 1;
    localparam int A_AFIQ = 2;

    always #10 clk = ~clk;

    vec_intc i_vec_intc (
        .clk(clk), .rst_n(rst_n), .src_level(src_level),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .fiq_req(fiq_req)
    );

    function automatic int bank_adr(int b, int off);
        return 16 + 8 * b + off;
    endfunction

    function automatic int lvl_adr(int n);
        return 64 + n;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'(a);
        #2;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        src_level = '0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        for (int b = 0; b < 3; b++) begin
            rd(bank_adr(b, 0), d); check("R1 mask reset", d, 32'hFFFF_FFFF);
        end
        rd(lvl_adr(5), d);  check("R1 level reset", d, 32'h0);
        rd(A_AIRQ, d);      check("R1 active irq reset", d, 32'h0);
        rd(A_AFIQ, d);      check("R1 active fiq reset", d, 32'h0);
        check("R1 irq_req low", 32'(irq_req), 32'h0);
        check("R1 fiq_req low", 32'(fiq_req), 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        do_reset();
        wr(bank_adr(1, 2), 32'h0000_00F0);
        rd(bank_adr(1, 0), d); check("R2 mask clear", d, 32'hFFFF_FF0F);
        wr(bank_adr(1, 1), 32'h0000_0010);
        rd(bank_adr(1, 0), d); check("R2 mask set", d, 32'hFFFF_FF1F);
        rd(bank_adr(0, 0), d); check("R10 other bank untouched", d, 32'hFFFF_FFFF);
        // Masked source forced by software: no pending, no request.
        wr(bank_adr(0, 3), 32'h8000_0000);
        tick();
        check("R2 masked no request", 32'(irq_req), 32'h0);
        rd(bank_adr(0, 5), d); check("R4 masked not pending", d, 32'h0);
        rd(bank_adr(0, 3), d); check("R3 soft readback", d, 32'h8000_0000);
        wr(bank_adr(0, 2), 32'h8000_0000);
        tick();
        check("R2 unmask raises request", 32'(irq_req), 32'h1);
        rd(A_AIRQ, d); check("R6 active vector 31", d, 32'h8000_001F);
    endtask

    task automatic t_soft_and_level();
        logic [31:0] d;
        do_reset();
        wr(bank_adr(1, 2), 32'h0000_0100);
        wr(bank_adr(1, 3), 32'h0000_0100);
        tick();
        check("R3 soft forces request", 32'(irq_req), 32'h1);
        rd(A_AIRQ, d); check("R10 source 40 vector", d, 32'h8000_0028);
        rd(bank_adr(1, 5), d); check("R4 pending irq bank1", d, 32'h0000_0100);
        wr(bank_adr(1, 4), 32'h0000_0100);
        rd(bank_adr(1, 5), d); check("R3 soft clear removes pending", d, 32'h0);
        check("R7 held after source gone", 32'(irq_req), 32'h1);
        wr(A_CTRL, 32'h1);
        check("R8 request low after ack", 32'(irq_req), 32'h0);
        tick();
        check("R8 no rearm without pending", 32'(irq_req), 32'h0);
        wr(bank_adr(2, 2), 32'h0000_0040);
        src_level[70] = 1'b1;
        tick();
        check("R4 level input request", 32'(irq_req), 32'h1);
        rd(A_AIRQ, d); check("R10 source 70 vector", d, 32'h8000_0046);
    endtask

    task automatic t_fiq_route();
        logic [31:0] d;
        do_reset();
        wr(lvl_adr(70), 32'h1);
        wr(bank_adr(2, 2), 32'h0000_0040);
        src_level[70] = 1'b1;
        tick();
        check("R4 fiq request", 32'(fiq_req), 32'h1);
        check("R4 irq stays low", 32'(irq_req), 32'h0);
        rd(bank_adr(2, 6), d); check("R4 pending fiq", d, 32'h0000_0040);
        rd(bank_adr(2, 5), d); check("R4 pending irq empty", d, 32'h0);
        rd(A_AFIQ, d); check("R6 active fiq vector", d, 32'h8000_0046);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        do_reset();
        wr(lvl_adr(3), 32'd20);
        wr(lvl_adr(10), 32'd8);
        wr(lvl_adr(20), 32'd8);
        wr(bank_adr(0, 2), 32'h0010_0408);
        wr(bank_adr(0, 3), 32'h0010_0408);
        tick();
        rd(A_AIRQ, d); check("R5 lowest value, tie to lower index", d, 32'h8000_000A);
        wr(bank_adr(0, 4), 32'h0000_0400);
        wr(A_CTRL, 32'h1);
        check("R8 drop after ack", 32'(irq_req), 32'h0);
        tick();
        rd(A_AIRQ, d); check("R5 next winner 20", d, 32'h8000_0014);
        wr(bank_adr(0, 4), 32'h0010_0000);
        wr(A_CTRL, 32'h1);
        tick();
        rd(A_AIRQ, d); check("R5 last winner 3", d, 32'h8000_0003);
    endtask

    task automatic t_freeze();
        logic [31:0] d;
        do_reset();
        wr(lvl_adr(3), 32'd20);
        wr(lvl_adr(10), 32'd8);
        wr(bank_adr(0, 2), 32'h0000_0408);
        wr(bank_adr(0, 3), 32'h0000_0008);
        tick();
        rd(A_AIRQ, d); check("R6 first winner 3", d, 32'h8000_0003);
        wr(bank_adr(0, 3), 32'h0000_0400);
        repeat (3) tick();
        rd(A_AIRQ, d); check("R7 vector frozen", d, 32'h8000_0003);
        check("R7 request held", 32'(irq_req), 32'h1);
        wr(A_CTRL, 32'h1);
        check("R8 gap cycle", 32'(irq_req), 32'h0);
        tick();
        rd(A_AIRQ, d); check("R8 rearbitrated to 10", d, 32'h8000_000A);
    endtask

    task automatic t_both_ack();
        logic [31:0] d;
        do_reset();
        wr(lvl_adr(5), 32'h1);
        wr(bank_adr(0, 2), 32'h0000_0060);
        wr(bank_adr(0, 3), 32'h0000_0060);
        tick();
        rd(A_AIRQ, d); check("R4 irq gets 6", d, 32'h8000_0006);
        rd(A_AFIQ, d); check("R4 fiq gets 5", d, 32'h8000_0005);
        wr(bank_adr(0, 4), 32'h0000_0060);
        wr(A_CTRL, 32'h3);
        check("R8 both irq ack", 32'(irq_req), 32'h0);
        check("R8 both fiq ack", 32'(fiq_req), 32'h0);
        tick();
        check("R8 irq stays low", 32'(irq_req), 32'h0);
        check("R8 fiq stays low", 32'(fiq_req), 32'h0);
    endtask

    task automatic t_level_reg();
        logic [31:0] d;
        do_reset();
        wr(lvl_adr(50), 32'hFFFF_FFFF);
        rd(lvl_adr(50), d); check("R9 upper bits read zero", d, 32'h0000_00FF);
        wr(lvl_adr(50), 32'h0000_0013);
        rd(lvl_adr(50), d); check("R9 readback", d, 32'h0000_0013);
        rd(lvl_adr(51), d); check("R9 neighbour untouched", d, 32'h0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_mask();
        t_soft_and_level();
        t_fiq_route();
        t_priority();
        t_freeze();
        t_both_ack();
        t_level_reg();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule